// File: doc/BRIEF.md
# SHA-256 Hash Engine with 32-bit Register Access

This block computes SHA-256 compressions behind a plain 32-bit register port. Software writes a 512-bit message block as sixteen 32-bit words into a set of holding registers, then writes a command word. The command either starts a fresh message from the standard initial hash value or continues a message from the digest left by the previous block. The engine takes a private copy of the block when a command is accepted. Once that copy is taken, the holding registers can be refilled with the following block while the current one is still being compressed.

Progress is reported through a status word with two flags. One flag shows that the engine is idle and can accept a command. The other shows that the digest registers hold a finished result. The eight digest words can be read at any time. The register port has no back-pressure: every access completes in the cycle it is presented. Read data is combinational and is valid in the same cycle as the select. Commands issued while the engine is busy are dropped. Software has to wait for the idle flag before it issues a command. Message padding is left to software.

Top module: `hashbus_sha256`

## Requirements
- R1: A read of address 0x00 returns the identification word (default 0x73686132), and a read of 0x01 returns the revision word (default 0x00010000).
- R2: A write to address 0x10+i (i = 0..15) stores block word i, and a read of the same address returns the stored value.
- R3: Writing 1 to bit 0 of the command register (0x08) hashes the held block as the first block of a message, starting from the standard initial hash value. Block word 0 is the first (most significant) message word. Digest word 0 (address 0x20) is the most significant 32 bits of the result, and words 1..7 follow at 0x21..0x27.
- R4: Writing 1 to bit 1 of the command register hashes the held block as a continuation, starting from the digest currently held.
- R5: Status bit 0 (ready) reads 1 after reset and while idle. It reads 0 from the second cycle after an accepted command write, and it returns to 1 between 64 and 70 cycles after that write.
- R6: Status bit 1 (valid) reads 0 after reset. It is cleared when a command is accepted and set when the result is written to the digest registers.
- R7: A command written while ready is 0 is ignored. The result in progress is unaffected, and no further run starts after it.
- R8: Block word writes made while a block is being hashed do not change the result of that block.
- R9: Reads of the command register and of every address outside 0x00, 0x01, 0x09, 0x10..0x1F and 0x20..0x27 return zero.
- R10: The digest words can be read whatever the valid flag shows. They read zero after reset, the initial hash value during a run started with bit 0, and the previous digest during a run started with bit 1.
- R11: If a command write sets both bit 0 and bit 1, the run starts from the initial hash value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Register access select |
| wr | input | 1 | 1 = write access, 0 = read access |
| addr | input | ADDR_W (8) | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational, zero when not reading |

## Verification
The bench uses the default parameters: an 8-bit address and the default identification and revision words. Because the address is only 8 bits wide, the bench can read every one of the 256 addresses and check that every unmapped location and the command register return zero. Each expected digest comes from a separate word-array model of the compression. The bench checks a single-block message, a two-block chained message whose second block is loaded while the first is being hashed, commands issued while busy, and a command with both bits set.

// File: rtl/hb_pkg.sv
package hb_pkg;

  localparam int WORD_W  = 32;
  localparam int BLK_WDS = 16;
  localparam int DIG_WDS = 8;
  localparam int ROUNDS  = 64;
  localparam int BLK_W   = WORD_W * BLK_WDS;
  localparam int DIG_W   = WORD_W * DIG_WDS;

  localparam int ADR_NAME = 'h00;
  localparam int ADR_VER  = 'h01;
  localparam int ADR_CMD  = 'h08;
  localparam int ADR_STAT = 'h09;
  localparam int ADR_BLK  = 'h10;
  localparam int ADR_DIG  = 'h20;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ROUND = 2'd1,
    ST_FINAL = 2'd2
  } core_state_e;

  localparam logic [DIG_W-1:0] IV_FLAT = {
    32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
    32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19
  };

  localparam logic [ROUNDS*WORD_W-1:0] K_FLAT = {
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5,
    32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3,
    32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc,
    32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7,
    32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13,
    32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3,
    32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5,
    32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208,
    32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
  };

  function automatic word_t rotr(input word_t x, input int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t big_s0(input word_t x);
    return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction

  function automatic word_t big_s1(input word_t x);
    return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction

  function automatic word_t sml_s0(input word_t x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic word_t sml_s1(input word_t x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction

  function automatic word_t choose(input word_t e, input word_t f, input word_t g);
    return (e & f) ^ (~e & g);
  endfunction

  function automatic word_t majority(input word_t a, input word_t b, input word_t c);
    return (a & b) ^ (a & c) ^ (b & c);
  endfunction

endpackage

// File: rtl/hb_wsched.sv
module hb_wsched
  import hb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic [BLK_W-1:0] block_i,
  output word_t            w_o
);

  word_t win_q [BLK_WDS];
  word_t w_new;

  // next schedule word from the current 16-word window
  assign w_new = sml_s1(win_q[14]) + win_q[9] + sml_s0(win_q[1]) + win_q[0];
  assign w_o   = win_q[0];

  for (genvar i = 0; i < BLK_WDS; i++) begin : g_win
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        win_q[i] <= '0;
      end else if (load_i) begin
        win_q[i] <= block_i[BLK_W-1-WORD_W*i -: WORD_W];
      end else if (shift_i) begin
        if (i == BLK_WDS-1) win_q[i] <= w_new;
        else                win_q[i] <= win_q[(i+1) % BLK_WDS];
      end
    end
  end

endmodule

// File: rtl/hb_core.sv
module hb_core
  import hb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_i,
  input  logic             next_i,
  input  logic [BLK_W-1:0] block_i,
  output logic             ready_o,
  output logic             valid_o,
  output logic [DIG_W-1:0] digest_o
);

  localparam int CNT_W = $clog2(ROUNDS);
  localparam logic [CNT_W-1:0] LAST_RND = CNT_W'(ROUNDS-1);

  core_state_e      state_q;
  logic [CNT_W-1:0] rnd_q;
  word_t            work_q [DIG_WDS];
  word_t            work_d [DIG_WDS];
  word_t            dig_q  [DIG_WDS];
  word_t            w_cur, k_cur, t1, t2;
  logic             start;
  logic             valid_q;

  assign ready_o = (state_q == ST_IDLE);
  assign valid_o = valid_q;
  assign start   = ready_o && (init_i || next_i);
  assign k_cur   = K_FLAT[(ROUNDS-1-int'(rnd_q))*WORD_W +: WORD_W];

  hb_wsched u_wsched (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (start),
    .shift_i (state_q == ST_ROUND),
    .block_i (block_i),
    .w_o     (w_cur)
  );

  always_comb begin
    t1 = work_q[7] + big_s1(work_q[4]) + choose(work_q[4], work_q[5], work_q[6])
       + k_cur + w_cur;
    t2 = big_s0(work_q[0]) + majority(work_q[0], work_q[1], work_q[2]);
    work_d[0] = t1 + t2;
    work_d[1] = work_q[0];
    work_d[2] = work_q[1];
    work_d[3] = work_q[2];
    work_d[4] = work_q[3] + t1;
    work_d[5] = work_q[4];
    work_d[6] = work_q[5];
    work_d[7] = work_q[6];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rnd_q   <= '0;
      valid_q <= 1'b0;
      for (int i = 0; i < DIG_WDS; i++) begin
        work_q[i] <= '0;
        dig_q[i]  <= '0;
      end
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            valid_q <= 1'b0;
            rnd_q   <= '0;
            state_q <= ST_ROUND;
            for (int i = 0; i < DIG_WDS; i++) begin
              if (init_i) begin
                work_q[i] <= IV_FLAT[DIG_W-1-WORD_W*i -: WORD_W];
                dig_q[i]  <= IV_FLAT[DIG_W-1-WORD_W*i -: WORD_W];
              end else begin
                work_q[i] <= dig_q[i];
              end
            end
          end
        end
        ST_ROUND: begin
          for (int i = 0; i < DIG_WDS; i++) work_q[i] <= work_d[i];
          rnd_q <= rnd_q + 1'b1;
          if (rnd_q == LAST_RND) state_q <= ST_FINAL;
        end
        ST_FINAL: begin
          for (int i = 0; i < DIG_WDS; i++) dig_q[i] <= dig_q[i] + work_q[i];
          valid_q <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < DIG_WDS; i++) begin : g_dig
    assign digest_o[DIG_W-1-WORD_W*i -: WORD_W] = dig_q[i];
  end

  // R5
  start_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && (init_i || next_i)) |=> !ready_o);

  // R6
  start_clears_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && (init_i || next_i)) |=> !valid_o);

  // R6
  valid_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ready_o);

  // R8
  digest_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ROUND) |=> $stable(digest_o));

endmodule

// File: rtl/hb_regfile.sv
module hb_regfile
  import hb_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  word_t             wdata_i,
  output logic [BLK_W-1:0]  block_o,
  output logic              init_o,
  output logic              next_o
);

  localparam logic [ADDR_W-1:0] CMD_A = ADDR_W'(ADR_CMD);

  word_t blk_q [BLK_WDS];
  logic  cmd_wr;

  assign cmd_wr = wr_i && (addr_i == CMD_A);

  for (genvar i = 0; i < BLK_WDS; i++) begin : g_blk
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        blk_q[i] <= '0;
      end else if (wr_i && addr_i == ADDR_W'(ADR_BLK + i)) begin
        blk_q[i] <= wdata_i;
      end
    end
    assign block_o[BLK_W-1-WORD_W*i -: WORD_W] = blk_q[i];
  end

  // single-cycle command strobes, cleared by hardware
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_o <= 1'b0;
      next_o <= 1'b0;
    end else begin
      init_o <= cmd_wr && wdata_i[0];
      next_o <= cmd_wr && wdata_i[1];
    end
  end

  // R3
  init_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_o) |-> $past(wr_i && (addr_i == CMD_A) && wdata_i[0]));

  // R4
  next_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(next_o) |-> $past(wr_i && (addr_i == CMD_A) && wdata_i[1]));

endmodule

// File: rtl/hashbus_sha256.sv
module hashbus_sha256
  import hb_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter logic [31:0] ID_WORD  = 32'h73686132,
  parameter logic [31:0] REV_WORD = 32'h00010000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata
);

  localparam int BIDX_W = $clog2(BLK_WDS);
  localparam int DIDX_W = $clog2(DIG_WDS);

  logic [BLK_W-1:0]  block;
  logic [DIG_W-1:0]  digest;
  logic              init_p, next_p, ready, valid;
  logic [BIDX_W-1:0] bidx;
  logic [DIDX_W-1:0] didx;
  logic              in_blk, in_dig;

  hb_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (sel && wr),
    .addr_i  (addr),
    .wdata_i (wdata),
    .block_o (block),
    .init_o  (init_p),
    .next_o  (next_p)
  );

  hb_core u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .init_i   (init_p),
    .next_i   (next_p),
    .block_i  (block),
    .ready_o  (ready),
    .valid_o  (valid),
    .digest_o (digest)
  );

  assign in_blk = (addr >= ADDR_W'(ADR_BLK)) && (addr < ADDR_W'(ADR_BLK + BLK_WDS));
  assign in_dig = (addr >= ADDR_W'(ADR_DIG)) && (addr < ADDR_W'(ADR_DIG + DIG_WDS));
  assign bidx   = BIDX_W'(addr - ADDR_W'(ADR_BLK));
  assign didx   = DIDX_W'(addr - ADDR_W'(ADR_DIG));

  always_comb begin
    rdata = '0;
    if (sel && !wr) begin
      if (addr == ADDR_W'(ADR_NAME))      rdata = ID_WORD;
      else if (addr == ADDR_W'(ADR_VER))  rdata = REV_WORD;
      else if (addr == ADDR_W'(ADR_STAT)) rdata = {30'd0, valid, ready};
      else if (in_blk) rdata = block[(BLK_WDS-1-int'(bidx))*WORD_W +: WORD_W];
      else if (in_dig) rdata = digest[(DIG_WDS-1-int'(didx))*WORD_W +: WORD_W];
    end
  end

  // R9
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> (rdata == 32'd0));

endmodule

// File: tb/hashbus_sha256_bench.sv
module hashbus_sha256_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0;
  logic        wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  hashbus_sha256 u_hashbus_sha256 (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  localparam logic [31:0] KT [64] = '{
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
  };
  localparam logic [255:0] START_H = {32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
                                      32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  // independent model: full 64-entry message array
  function automatic logic [255:0] model(input logic [255:0] hin, input logic [31:0] b [16]);
    logic [31:0] w [64];
    logic [31:0] v [8];
    logic [31:0] s0, s1, x1, x2;
    logic [255:0] r;
    for (int t = 0; t < 64; t++) begin
      if (t < 16) w[t] = b[t];
      else begin
        s0 = rr(w[t-15], 7) ^ rr(w[t-15], 18) ^ (w[t-15] >> 3);
        s1 = rr(w[t-2], 17) ^ rr(w[t-2], 19) ^ (w[t-2] >> 10);
        w[t] = w[t-16] + s0 + w[t-7] + s1;
      end
    end
    for (int j = 0; j < 8; j++) v[j] = hin[255-32*j -: 32];
    for (int t = 0; t < 64; t++) begin
      x1 = v[7] + (rr(v[4], 6) ^ rr(v[4], 11) ^ rr(v[4], 25))
         + ((v[4] & v[5]) ^ (~v[4] & v[6])) + KT[t] + w[t];
      x2 = (rr(v[0], 2) ^ rr(v[0], 13) ^ rr(v[0], 22))
         + ((v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]));
      for (int j = 7; j > 0; j--) v[j] = v[j-1];
      v[4] = v[4] + x1;
      v[0] = x1 + x2;
    end
    for (int j = 0; j < 8; j++) r[255-32*j -: 32] = hin[255-32*j -: 32] + v[j];
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = a;
    #2;
    d = rdata;
    sel = 1'b0;
  endtask

  task automatic load_block(input logic [31:0] b [16]);
    for (int i = 0; i < 16; i++) bus_write(8'(8'h10 + i), b[i]);
  endtask

  task automatic wait_ready(output int lat, input int from_cyc);
    logic [31:0] s;
    for (int n = 0; n < 200; n++) begin
      bus_read(8'h09, s);
      if (s[0]) break;
    end
    lat = cyc - from_cyc;
  endtask

  // scoreboard
  typedef struct { logic [255:0] dig; string req; } exp_t;
  exp_t sb_q [$];
  event mon_req, mon_done;

  task automatic push_and_compare(input logic [255:0] d, input string req);
    exp_t e;
    e.dig = d; e.req = req;
    sb_q.push_back(e);
    -> mon_req;
    @(mon_done);
  endtask

  initial begin : monitor
    forever begin
      exp_t e;
      logic [31:0] got;
      @(mon_req);
      e = sb_q.pop_front();
      for (int i = 0; i < 8; i++) begin
        bus_read(8'(8'h20 + i), got);
        check(e.req, got, e.dig[255-32*i -: 32]);
      end
      -> mon_done;
    end
  end

  initial begin : watchdog
    #(8 * 150000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : driver
    logic [31:0] ba [16], b1 [16], b2 [16], bc [16], bd [16];
    logic [31:0] r;
    logic [255:0] h1, h2, hc, hd;
    int lat, t0;

    for (int i = 0; i < 16; i++) begin
      ba[i] = '0; b2[i] = '0;
      b1[i] = {8'h61 + 8'(i), 8'h62 + 8'(i), 8'h63 + 8'(i), 8'h64 + 8'(i)};
      bc[i] = (32'h9e3779b9 * (i + 1)) ^ 32'h0f1e2d3c;
      bd[i] = {16'(i * 3 + 7), ~16'(i * 5)};
    end
    ba[0] = 32'h61626380; ba[15] = 32'h00000018;
    b1[14] = 32'h80000000; b1[15] = 32'h00000000;
    b2[15] = 32'h000001c0;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    bus_read(8'h09, r); check("R5 R6 reset status", r, 32'h1);
    bus_read(8'h20, r); check("R10 reset digest", r, 32'h0);
    bus_read(8'h00, r); check("R1 id", r, 32'h73686132);
    bus_read(8'h01, r); check("R1 rev", r, 32'h00010000);

    // R9: scan every unmapped address plus command register
    for (int a = 0; a < 256; a++) begin
      if (!(a == 0 || a == 1 || a == 9 || (a >= 16 && a < 40))) begin
        bus_read(8'(a), r);
        check("R9 unmapped", r, 32'h0);
      end
    end

    // R2 block write/readback
    load_block(bc);
    for (int i = 0; i < 16; i++) begin
      bus_read(8'(8'h10 + i), r);
      check("R2 readback", r, bc[i]);
    end

    // R3 single-block message from initial value
    load_block(ba);
    bus_write(8'h08, 32'h1);
    t0 = cyc;
    bus_read(8'h09, r); check("R5 busy", r, 32'h0);
    bus_read(8'h20, r); check("R10 iv during init run", r, 32'h6a09e667);
    wait_ready(lat, t0);
    tests++;
    if (lat < 64 || lat > 70) begin
      fails++;
      $display("FAIL R5 latency: actual %0d expected 64..70", lat);
    end
    bus_read(8'h09, r); check("R6 valid set", r, 32'h3);
    push_and_compare(model(START_H, ba), "R3 single block");

    // R8 + R4: second block loaded during first block
    load_block(b1);
    bus_write(8'h08, 32'h1);
    load_block(b2);
    wait_ready(lat, cyc);
    h1 = model(START_H, b1);
    push_and_compare(h1, "R8 first of chain");
    bus_write(8'h08, 32'h2);
    bus_read(8'h09, r); check("R6 valid cleared", r, 32'h0);
    bus_read(8'h20, r); check("R10 previous digest during next run", r, h1[255:224]);
    wait_ready(lat, cyc);
    h2 = model(h1, b2);
    push_and_compare(h2, "R4 chained");

    // R7 commands while busy ignored
    load_block(bc);
    bus_write(8'h08, 32'h1);
    bus_write(8'h08, 32'h2);
    bus_write(8'h08, 32'h1);
    wait_ready(lat, cyc);
    hc = model(START_H, bc);
    push_and_compare(hc, "R7 busy command ignored");
    repeat (6) @(negedge clk);
    bus_read(8'h09, r); check("R7 no extra run", r, 32'h3);
    push_and_compare(hc, "R7 digest unchanged");

    // R11 both bits: initial value wins
    load_block(bd);
    bus_write(8'h08, 32'h3);
    wait_ready(lat, cyc);
    hd = model(START_H, bd);
    push_and_compare(hd, "R11 init priority");

    // R4 continuation with another pattern
    load_block(bc);
    bus_write(8'h08, 32'h2);
    wait_ready(lat, cyc);
    push_and_compare(model(hd, bc), "R4 chain pattern");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule